// File: doc/BRIEF.md
# Mode-0 Parallel Port Bank

This block is a group of 24 general-purpose I/O lines organised as three 8-bit ports, named A, B and C. Every port works only as a plain input or a plain output, with no handshake. Port C is split into a low nibble and a high nibble, and each nibble has its own direction. A host reads and writes the ports and one configuration word through a small register interface. Reads return the output latch for lines that drive and the synchronised pin level for lines that listen.

Each port has a strap input that forces it to drive, whatever the configuration word says. There are two reset inputs:

- A power-on reset always clears the bank.
- A warm reset clears the bank only while the protection input is low. With protection high, the directions and output levels in place before the warm reset survive it, so the driven lines do not glitch.

The output latch of an input port can be written. This lets software load a safe level before it turns the port into an output.

Top module: `pp_bank`

## Requirements
- R1: After power-on reset, the configuration word reads 0, all `pin_oe` bits are 0 and all `pin_out` bits are 0.
- R2: A write to address 0, 1 or 2 loads the output latch of port A, B or C at the next clock edge, whatever the port's direction. The latch value appears on the matching `pin_out` bits.
- R3: Address 3 holds the configuration word. Bit 0 sets the direction of port A, bit 1 port B, bit 2 port C bits 3:0, and bit 3 port C bits 7:4, where 1 means output. A read of address 3 returns the stored bits in `rdata[3:0]` with zeros above them.
- R4: A read of a data port returns the latch value on bits whose group drives, and the pin value on bits whose group is an input. A pin change reaches `rdata` after exactly two rising clock edges.
- R5: A high `strap_out` bit (bit 0 for A, bit 1 for B, bit 2 for C low, bit 3 for C high) sets `pin_oe` high for that group at once. The configuration word read back is not changed by the strap.
- R6: A warm reset while `protect_en` is 1 leaves the configuration word and all output latches unchanged.
- R7: A warm reset while `protect_en` is 0 clears the configuration word and all latches. Groups forced by a strap then drive all zeros.
- R8: Writes presented while `warm_rst_n` is low are ignored.
- R9: The two nibbles of port C follow their own direction bits, so one read of port C can mix latch bits and pin bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asserted asynchronously |
| warm_rst_n | input | 1 | Warm reset, active low, sampled on the clock |
| protect_en | input | 1 | Keeps state across a warm reset when high |
| strap_out | input | 4 | Per-group force-to-output straps |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 A, 1 B, 2 C, 3 configuration |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| pin_in | input | 24 | Pin levels, C in bits 23:16, B in 15:8, A in 7:0 |
| pin_out | output | 24 | Output latch values, same layout |
| pin_oe | output | 24 | Per-line output enable, same layout |

## Verification
The hardest case to reach is a warm reset that lands on a cycle where a host write is also pending, with the straps forcing some groups at the same time. The protected and unprotected outcomes differ only in state that stays out of sight until it is read back. The stimulus first sets up a mixed configuration with non-zero latches. It then holds the warm reset low while it presents a write, and afterwards reads every register and compares `pin_oe` and `pin_out` for each setting of `protect_en`.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CFG = 2'd3
  } pp_sel_e;

  localparam int unsigned DIR_GROUPS = 4;
endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      q        <= '0;
    end else begin
      stage1_q <= d;
      q        <= stage1_q;
    end
  end
endmodule

// File: rtl/pp_state.sv
module pp_state
  import pp_pkg::*;
#(
  parameter int unsigned PW = 8
) (
  input  logic                  clk,
  input  logic                  por_n,
  input  logic                  clr,
  input  logic                  we,
  input  pp_sel_e               sel,
  input  logic [PW-1:0]         wdata,
  output logic [3*PW-1:0]       lat_q,
  output logic [DIR_GROUPS-1:0] cfg_q
);
  logic [3*PW-1:0]       lat_d;
  logic [DIR_GROUPS-1:0] cfg_d;
  logic                  lat_en;
  logic                  cfg_en;

  always_comb begin
    lat_d  = lat_q;
    cfg_d  = cfg_q;
    lat_en = 1'b0;
    cfg_en = 1'b0;
    if (clr) begin
      lat_d  = '0;
      cfg_d  = '0;
      lat_en = 1'b1;
      cfg_en = 1'b1;
    end else if (we) begin
      case (sel)
        SEL_A:   begin lat_d[0*PW +: PW] = wdata; lat_en = 1'b1; end
        SEL_B:   begin lat_d[1*PW +: PW] = wdata; lat_en = 1'b1; end
        SEL_C:   begin lat_d[2*PW +: PW] = wdata; lat_en = 1'b1; end
        default: begin cfg_d = wdata[DIR_GROUPS-1:0]; cfg_en = 1'b1; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lat_q <= '0;
    end else if (lat_en) begin
      lat_q <= lat_d;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end
endmodule

// File: rtl/pp_bank.sv
module pp_bank
  import pp_pkg::*;
#(
  parameter int unsigned PORT_W = 8
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                warm_rst_n,
  input  logic                protect_en,
  input  logic [3:0]          strap_out,
  input  logic                wr_en,
  input  logic [1:0]          addr,
  input  logic [PORT_W-1:0]   wdata,
  output logic [PORT_W-1:0]   rdata,
  input  logic [3*PORT_W-1:0] pin_in,
  output logic [3*PORT_W-1:0] pin_out,
  output logic [3*PORT_W-1:0] pin_oe
);
  localparam int unsigned LINES = 3 * PORT_W;
  localparam int unsigned HALF  = PORT_W / 2;

  logic [LINES-1:0]      lat_q;
  logic [LINES-1:0]      syn_q;
  logic [LINES-1:0]      mix;
  logic [DIR_GROUPS-1:0] cfg_q;
  logic [DIR_GROUPS-1:0] dir_eff;
  logic                  clr;
  logic                  we;
  pp_sel_e               sel;

  assign clr = !warm_rst_n && !protect_en;
  assign we  = wr_en && warm_rst_n;
  assign sel = pp_sel_e'(addr);

  pp_state #(.PW(PORT_W)) state_i (
    .clk   (clk),
    .por_n (por_n),
    .clr   (clr),
    .we    (we),
    .sel   (sel),
    .wdata (wdata),
    .lat_q (lat_q),
    .cfg_q (cfg_q)
  );

  pp_sync #(.W(LINES)) sync_i (
    .clk   (clk),
    .rst_n (por_n),
    .d     (pin_in),
    .q     (syn_q)
  );

  assign dir_eff = cfg_q | strap_out;

  for (genvar g = 0; g < DIR_GROUPS; g++) begin : g_grp
    localparam int unsigned LO = (g < 2) ? g * PORT_W : 2 * PORT_W + (g - 2) * HALF;
    localparam int unsigned GW = (g < 2) ? PORT_W : HALF;
    assign pin_oe[LO +: GW] = {GW{dir_eff[g]}};
  end

  assign pin_out = lat_q;
  assign mix     = (pin_oe & lat_q) | (~pin_oe & syn_q);

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_A:   rdata = mix[0*PORT_W +: PORT_W];
      SEL_B:   rdata = mix[1*PORT_W +: PORT_W];
      SEL_C:   rdata = mix[2*PORT_W +: PORT_W];
      default: rdata[DIR_GROUPS-1:0] = cfg_q;
    endcase
  end
endmodule

// File: rtl/pp_bank_chk.sv
module pp_bank_chk #(
  parameter int unsigned PORT_W = 8
) (
  input logic                clk,
  input logic                por_n,
  input logic                warm_rst_n,
  input logic                protect_en,
  input logic [3:0]          strap_out,
  input logic                wr_en,
  input logic [1:0]          addr,
  input logic [PORT_W-1:0]   wdata,
  input logic [PORT_W-1:0]   rdata,
  input logic [3*PORT_W-1:0] pin_in,
  input logic [3*PORT_W-1:0] pin_out,
  input logic [3*PORT_W-1:0] pin_oe
);
  p_strap_r5: assert property (@(posedge clk) disable iff (!por_n)
    strap_out[0] |-> (&pin_oe[PORT_W-1:0]));

  p_write_a_r2: assert property (@(posedge clk) disable iff (!por_n)
    (warm_rst_n && wr_en && addr == 2'd0) |=> (pin_out[PORT_W-1:0] == $past(wdata)));

  p_keep_r6: assert property (@(posedge clk) disable iff (!por_n)
    (!warm_rst_n && protect_en) |=> $stable(pin_out));

  p_clear_r7: assert property (@(posedge clk) disable iff (!por_n)
    (!warm_rst_n && !protect_en) |=> (pin_out == '0));

  p_rdout_r4: assert property (@(posedge clk) disable iff (!por_n)
    (addr == 2'd0) |-> ((rdata & pin_oe[PORT_W-1:0]) == (pin_out[PORT_W-1:0] & pin_oe[PORT_W-1:0])));
endmodule

bind pp_bank pp_bank_chk #(.PORT_W(PORT_W)) chk_i (
  .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .protect_en(protect_en),
  .strap_out(strap_out), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
  .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/pp_bank_tb_top.sv
module pp_bank_tb_top;
  logic        clk = 1'b0;
  logic        por_n;
  logic        warm_rst_n;
  logic        protect_en;
  logic [3:0]  strap_out;
  logic        wr_en;
  logic [1:0]  addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic [23:0] pin_in;
  logic [23:0] pin_out;
  logic [23:0] pin_oe;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  pp_bank dut_i (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .protect_en(protect_en),
    .strap_out(strap_out), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // {write, addr, data, expected read}
  localparam logic [18:0] VEC [13] = '{
    {1'b0, 2'd3, 8'h00, 8'h00},  // R1 config clear
    {1'b0, 2'd0, 8'h00, 8'hA5},  // R4 input reads pins
    {1'b1, 2'd0, 8'h77, 8'h00},  // R2 load latch of input port
    {1'b0, 2'd0, 8'h00, 8'hA5},  // R2 still pins while input
    {1'b1, 2'd3, 8'h01, 8'h00},  // R3 A output
    {1'b0, 2'd0, 8'h00, 8'h77},  // R4 latch read back
    {1'b1, 2'd2, 8'hF0, 8'h00},
    {1'b1, 2'd3, 8'h05, 8'h00},  // R3 A and C low out
    {1'b0, 2'd2, 8'h00, 8'h30},  // R9 low latch, high pins
    {1'b1, 2'd3, 8'h0B, 8'h00},  // R3 A, B, C high out
    {1'b0, 2'd1, 8'h00, 8'h00},  // R3 B drives latch zero
    {1'b0, 2'd2, 8'h00, 8'hFC},  // R9 high latch, low pins
    {1'b0, 2'd3, 8'h00, 8'h0B}   // R3 config read back
  };

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check24(input string req, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = wr;
    addr  = a;
    wdata = d;
    #1;
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    por_n = 1'b0; warm_rst_n = 1'b1; protect_en = 1'b0; strap_out = 4'h0;
    wr_en = 1'b0; addr = 2'd0; wdata = 8'h00; pin_in = 24'h3C5AA5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    por_n = 1'b1;
    #1;
    check24("R1 oe", pin_oe, 24'h0);
    check24("R1 out", pin_out, 24'h0);
    repeat (2) @(posedge clk);

    for (int i = 0; i < 13; i++) begin
      step(VEC[i][18], VEC[i][17:16], VEC[i][15:8]);
      if (!VEC[i][18]) check8($sformatf("R3/R4/R9 vec %0d", i), rdata, VEC[i][7:0]);
    end

    // R4: two-edge synchronizer on C low nibble (input)
    step(1'b0, 2'd2, 8'h00);
    pin_in[23:16] = 8'h39;
    @(negedge clk); #1;
    check8("R4 one edge", rdata, 8'hFC);
    @(negedge clk); #1;
    check8("R4 two edges", rdata, 8'hF9);

    // R5: strap forces C low out, config unchanged
    strap_out = 4'b0100;
    #1;
    check24("R5 oe", pin_oe, 24'hFF_FF_FF & 24'hFFFFFF);
    check8("R5 read C", rdata, 8'hF0);
    step(1'b0, 2'd3, 8'h00);
    check8("R5 cfg", rdata, 8'h0B);

    // R6 and R8: protected warm reset with a write pending
    protect_en = 1'b1;
    @(negedge clk);
    warm_rst_n = 1'b0; wr_en = 1'b1; addr = 2'd0; wdata = 8'h11;
    @(negedge clk);
    warm_rst_n = 1'b1; wr_en = 1'b0;
    #1;
    check8("R8 write ignored", rdata, 8'h77);
    check24("R6 out kept", pin_out, 24'hF0_00_77);
    step(1'b0, 2'd3, 8'h00);
    check8("R6 cfg kept", rdata, 8'h0B);

    // R7: unprotected warm reset, straps on A and C low
    protect_en = 1'b0;
    strap_out  = 4'b0101;
    @(negedge clk);
    warm_rst_n = 1'b0;
    @(negedge clk);
    warm_rst_n = 1'b1;
    #1;
    check8("R7 cfg clear", rdata, 8'h00);
    check24("R7 out zero", pin_out, 24'h0);
    check24("R7 strap oe", pin_oe, 24'h0F00FF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule